// File: doc/BRIEF.md
# Fault Vector Catch Halt Controller

This block sits beside a processor core and turns selected fault and reset events into debug halt requests. Software or a debugger programs a control word holding one catch-enable bit per event class and a monitor-enable bit. When the global halting-debug enable is high and an enabled event class pulses, a halt request is armed. The core can only stop between instructions, so the armed request is released onto the halt output at the first instruction boundary that falls outside exception vectoring and outside core reset. The core therefore stops on the first instruction of the handler that the event started.

While a request is armed and the core is vectoring, the block tells the exception logic to refuse late-arriving interrupt preemption. If a second fault hits during vectoring, the halt waits for that fault's own vectoring to finish and is flagged as redirected. When halting debug is off, the block tells the core where debug events should go instead: to the debug monitor exception or to the hard fault handler. A sticky cause field records every event class that armed the current request. Only one request is held at a time, and it clears when the core acknowledges the halt.

Top module: `fvc_halt_ctrl`

## Requirements
- R1: After reset the control word reads zero and halt_req, halt_redirect, late_arr_block and trig_cause are all zero.
- R2: The control word holds the monitor enable at bit 16. It holds catch enables at bit 0 for event 0 and at bit k+3 for event k, k = 1..7. A write is visible on cfg_rd_data one cycle later. Bits 1 to 3 and 11 to 15 always read zero, whatever is written to them.
- R3: An enabled event pulse (evt_pulse[k] with its catch bit set and dbg_halt_en high) arms a request. halt_req rises in the cycle after the first insn_bound sampled with vec_active low and core_in_reset low, and not earlier.
- R4: While dbg_halt_en is low, event pulses arm nothing, whatever the catch bits hold.
- R5: A pulse on an event class whose catch bit is clear arms nothing.
- R6: If vec_fault is seen while a request is armed, halt_redirect is high together with halt_req when the halt is issued.
- R7: late_arr_block is high exactly while a request is armed (not yet halted) and vec_active is high.
- R8: With dbg_halt_en high, route_monitor and route_hardfault are both low. With it low, route_monitor equals the monitor enable and route_hardfault is its inverse.
- R9: A reset-class catch (event 0) armed while core_in_reset is high is held through core reset. halt_req rises only after a boundary seen with core_in_reset low.
- R10: halt_req stays high until halt_ack and is low in the cycle after halt_ack. Events seen while armed or halted queue no second halt.
- R11: Several enabled events in one cycle arm one request, and trig_cause holds the OR of their event bits until the next request is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 17 | Control word write value |
| cfg_rd_data | output | 17 | Control word read value |
| dbg_halt_en | input | 1 | Global halting-debug enable |
| evt_pulse | input | 8 | One pulse per event class (0 reset, 1 mem-manage, 2 coprocessor, 3 check, 4 state, 5 bus, 6 entry/return, 7 hard fault) |
| insn_bound | input | 1 | Instruction boundary strobe |
| vec_active | input | 1 | Exception vectoring in progress |
| vec_fault | input | 1 | Fault (vector read or stack push) during vectoring |
| core_in_reset | input | 1 | Core held in reset |
| halt_ack | input | 1 | Core reports the halt has been taken |
| halt_req | output | 1 | Debug halt request |
| halt_redirect | output | 1 | Halt lands on a nested fault handler |
| late_arr_block | output | 1 | Suppress late-arrival preemption |
| route_monitor | output | 1 | Debug events go to the monitor exception |
| route_hardfault | output | 1 | Debug events go to hard fault |
| trig_cause | output | 8 | Sticky event classes of the armed request |

## Verification
Registered results (the armed state, halt_req, halt_redirect, trig_cause and the control word read value) change on the rising edge that samples their cause. halt_req appears one cycle after the qualifying boundary, and it clears one cycle after halt_ack. late_arr_block and both routing outputs are combinational from the armed state and the current inputs, so they are due in the same cycle. The driver applies each stimulus after a falling edge and queues the expected values for the next rising edge. The monitor compares them at the following falling edge, when registered and combinational results are both settled.

// File: rtl/fvc_pkg.sv
package fvc_pkg;

  localparam int unsigned FVC_NEVT    = 8;
  localparam int unsigned FVC_CFGW    = 17;
  localparam int unsigned FVC_MON_BIT = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_HALT = 2'd2
  } fvc_state_e;

  // Control-word position of the catch bit for event class k.
  function automatic int unsigned evt_cfg_pos(input int unsigned k);
    return (k == 0) ? 0 : k + 3;
  endfunction

  // Bits that hold state; every other position reads as zero.
  function automatic logic [FVC_CFGW-1:0] cfg_legal_mask();
    logic [FVC_CFGW-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < FVC_NEVT; k++) m[evt_cfg_pos(k)] = 1'b1;
    m[FVC_MON_BIT] = 1'b1;
    return m;
  endfunction

  // Gather the catch enables into event-class order.
  function automatic logic [FVC_NEVT-1:0] cfg_catch_bits(input logic [FVC_CFGW-1:0] c);
    logic [FVC_NEVT-1:0] e;
    for (int unsigned k = 0; k < FVC_NEVT; k++) e[k] = c[evt_cfg_pos(k)];
    return e;
  endfunction

endpackage

// File: rtl/fvc_cfg_reg.sv
module fvc_cfg_reg
  import fvc_pkg::*;
#(
  parameter int unsigned CFGW = FVC_CFGW,
  parameter int unsigned NEVT = FVC_NEVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CFGW-1:0] wr_data,
  output logic [CFGW-1:0] rd_data,
  output logic            mon_en,
  output logic [NEVT-1:0] catch_en
);

  localparam logic [CFGW-1:0] LEGAL = cfg_legal_mask();

  logic [CFGW-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & LEGAL;
  end

  assign rd_data  = cfg_q;
  assign mon_en   = cfg_q[FVC_MON_BIT];
  assign catch_en = cfg_catch_bits(cfg_q);

endmodule

// File: rtl/fvc_catch_match.sv
module fvc_catch_match #(
  parameter int unsigned NEVT = 8
) (
  input  logic [NEVT-1:0] catch_en,
  input  logic [NEVT-1:0] evt_pulse,
  input  logic            dbg_halt_en,
  output logic [NEVT-1:0] hit,
  output logic            hit_any
);

  for (genvar k = 0; k < NEVT; k++) begin : g_hit
    assign hit[k] = evt_pulse[k] & catch_en[k] & dbg_halt_en;
  end

  assign hit_any = |hit;

endmodule

// File: rtl/fvc_route.sv
module fvc_route (
  input  logic dbg_halt_en,
  input  logic mon_en,
  output logic route_monitor,
  output logic route_hardfault
);

  assign route_monitor   = ~dbg_halt_en &  mon_en;
  assign route_hardfault = ~dbg_halt_en & ~mon_en;

endmodule

// File: rtl/fvc_halt_fsm.sv
module fvc_halt_fsm
  import fvc_pkg::*;
#(
  parameter int unsigned NEVT = FVC_NEVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] hit,
  input  logic            hit_any,
  input  logic            insn_bound,
  input  logic            vec_active,
  input  logic            vec_fault,
  input  logic            core_in_reset,
  input  logic            halt_ack,
  output logic            pend,
  output logic            halt_req,
  output logic            redir,
  output logic [NEVT-1:0] cause
);

  fvc_state_e state_q, state_d;
  logic       bound_ok;

  // A halt may only land on a boundary outside vectoring and core reset.
  assign bound_ok = insn_bound & ~vec_active & ~core_in_reset;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hit_any)  state_d = ST_PEND;
      ST_PEND: if (bound_ok) state_d = ST_HALT;
      ST_HALT: if (halt_ack) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      redir   <= 1'b0;
      cause   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && hit_any) begin
        cause <= hit;
        redir <= 1'b0;
      end else if (state_q == ST_PEND && vec_fault) begin
        redir <= 1'b1;
      end
    end
  end

  assign pend     = (state_q == ST_PEND);
  assign halt_req = (state_q == ST_HALT);

endmodule

// File: rtl/fvc_halt_ctrl.sv
module fvc_halt_ctrl
  import fvc_pkg::*;
#(
  parameter int unsigned NEVT = FVC_NEVT,
  parameter int unsigned CFGW = FVC_CFGW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [CFGW-1:0] cfg_wr_data,
  output logic [CFGW-1:0] cfg_rd_data,
  input  logic            dbg_halt_en,
  input  logic [NEVT-1:0] evt_pulse,
  input  logic            insn_bound,
  input  logic            vec_active,
  input  logic            vec_fault,
  input  logic            core_in_reset,
  input  logic            halt_ack,
  output logic            halt_req,
  output logic            halt_redirect,
  output logic            late_arr_block,
  output logic            route_monitor,
  output logic            route_hardfault,
  output logic [NEVT-1:0] trig_cause
);

  logic            mon_en_w;
  logic [NEVT-1:0] catch_en_w;
  logic [NEVT-1:0] hit_w;
  logic            hit_any_w;
  logic            pend_w;
  logic            redir_w;

  fvc_cfg_reg #(.CFGW(CFGW), .NEVT(NEVT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .rd_data  (cfg_rd_data),
    .mon_en   (mon_en_w),
    .catch_en (catch_en_w)
  );

  fvc_catch_match #(.NEVT(NEVT)) u_match (
    .catch_en    (catch_en_w),
    .evt_pulse   (evt_pulse),
    .dbg_halt_en (dbg_halt_en),
    .hit         (hit_w),
    .hit_any     (hit_any_w)
  );

  fvc_route u_route (
    .dbg_halt_en     (dbg_halt_en),
    .mon_en          (mon_en_w),
    .route_monitor   (route_monitor),
    .route_hardfault (route_hardfault)
  );

  fvc_halt_fsm #(.NEVT(NEVT)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit           (hit_w),
    .hit_any       (hit_any_w),
    .insn_bound    (insn_bound),
    .vec_active    (vec_active),
    .vec_fault     (vec_fault),
    .core_in_reset (core_in_reset),
    .halt_ack      (halt_ack),
    .pend          (pend_w),
    .halt_req      (halt_req),
    .redir         (redir_w),
    .cause         (trig_cause)
  );

  assign late_arr_block = pend_w & vec_active;
  assign halt_redirect  = halt_req & redir_w;

endmodule

// File: rtl/fvc_halt_ctrl_chk.sv
module fvc_halt_ctrl_chk
  import fvc_pkg::*;
#(
  parameter int unsigned NEVT = FVC_NEVT,
  parameter int unsigned CFGW = FVC_CFGW
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CFGW-1:0] cfg_rd_data,
  input logic            dbg_halt_en,
  input logic            insn_bound,
  input logic            vec_active,
  input logic            core_in_reset,
  input logic            halt_ack,
  input logic            halt_req,
  input logic            halt_redirect,
  input logic            late_arr_block,
  input logic            route_monitor,
  input logic            route_hardfault,
  input logic            pend_w
);

  localparam logic [CFGW-1:0] LEGAL = cfg_legal_mask();

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~LEGAL) == '0);

  // R3
  halt_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> ($past(insn_bound) && !$past(vec_active) && !$past(core_in_reset)));

  // R4
  nodbg_noarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_w && !halt_req && !dbg_halt_en) |=> !pend_w);

  // R6
  redirect_only_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_redirect |-> halt_req);

  // R7
  late_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_arr_block |-> (vec_active && !halt_req));

  // R8
  route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt_en |-> (!route_monitor && !route_hardfault));

  // R8
  route_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_halt_en |-> (route_monitor == cfg_rd_data[FVC_MON_BIT] && route_hardfault != route_monitor));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !halt_ack) |=> halt_req);

  // R10
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && halt_ack) |=> !halt_req);

endmodule

bind fvc_halt_ctrl fvc_halt_ctrl_chk #(.NEVT(NEVT), .CFGW(CFGW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_rd_data     (cfg_rd_data),
  .dbg_halt_en     (dbg_halt_en),
  .insn_bound      (insn_bound),
  .vec_active      (vec_active),
  .core_in_reset   (core_in_reset),
  .halt_ack        (halt_ack),
  .halt_req        (halt_req),
  .halt_redirect   (halt_redirect),
  .late_arr_block  (late_arr_block),
  .route_monitor   (route_monitor),
  .route_hardfault (route_hardfault),
  .pend_w          (pend_w)
);

// File: tb/sim_fvc_halt_ctrl.sv
module sim_fvc_halt_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [16:0] cfg_wr_data = '0;
  logic [16:0] cfg_rd_data;
  logic        dbg_halt_en = 1'b0;
  logic [7:0]  evt_pulse = '0;
  logic        insn_bound = 1'b0;
  logic        vec_active = 1'b0;
  logic        vec_fault = 1'b0;
  logic        core_in_reset = 1'b0;
  logic        halt_ack = 1'b0;
  logic        halt_req, halt_redirect, late_arr_block, route_monitor, route_hardfault;
  logic [7:0]  trig_cause;

  always #10 clk = ~clk;

  fvc_halt_ctrl u0 (.*);

  typedef struct {
    string       req;
    logic        halt, redir, late, rmon, rhf;
    logic [7:0]  cause;
    logic [16:0] cfg;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // bench-side expected state
  logic        e_pend = 0, e_halt = 0, e_redir = 0;
  logic [7:0]  e_cause = '0;
  logic [16:0] e_cfg = '0;

  task automatic cmp(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  // monitor: compare queued expectations once outputs settle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.req, "halt_req",        32'(halt_req),        32'(it.halt));
      cmp(it.req, "halt_redirect",   32'(halt_redirect),   32'(it.redir));
      cmp(it.req, "late_arr_block",  32'(late_arr_block),  32'(it.late));
      cmp(it.req, "route_monitor",   32'(route_monitor),   32'(it.rmon));
      cmp(it.req, "route_hardfault", 32'(route_hardfault), 32'(it.rhf));
      cmp(it.req, "trig_cause",      32'(trig_cause),      32'(it.cause));
      cmp(it.req, "cfg_rd_data",     32'(cfg_rd_data),     32'(it.cfg));
    end
  end

  // driver: one rising edge, then queue what the requirements predict
  task automatic tick(string req);
    item_t it;
    @(posedge clk);
    #2;
    it.req   = req;
    it.halt  = e_halt;
    it.redir = e_halt & e_redir;
    it.late  = e_pend & vec_active;
    it.rmon  = ~dbg_halt_en &  e_cfg[16];
    it.rhf   = ~dbg_halt_en & ~e_cfg[16];
    it.cause = e_cause;
    it.cfg   = e_cfg;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic quiet();
    cfg_wr_en = 0; evt_pulse = '0; insn_bound = 0;
    vec_fault = 0; halt_ack = 0; vec_active = 0;
  endtask

  task automatic wr(string req, logic [16:0] d, logic [16:0] keep);
    cfg_wr_en = 1; cfg_wr_data = d; e_cfg = keep;
    tick(req);
    quiet();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state, routing to hard fault with debug off and monitor clear
    tick("R1");

    // R2: reserved positions read zero, legal ones hold
    wr("R2", 17'h1FFFF, 17'h107F1);
    wr("R2", 17'h0F80E, 17'h00000);
    wr("R2", 17'h007F1, 17'h007F1);

    // R4: debug disabled, every class pulsed, then a boundary
    dbg_halt_en = 0; evt_pulse = 8'hFF; tick("R4");
    quiet(); insn_bound = 1; tick("R4");
    quiet();

    // R8: monitor enable routes debug events to the monitor
    wr("R8", 17'h107F1, 17'h107F1);
    dbg_halt_en = 1; tick("R8");

    // R3: arm with mem-manage (event 1), no early halt
    evt_pulse = 8'h02; e_pend = 1; e_cause = 8'h02; tick("R3");
    quiet(); tick("R3");
    // R7: boundary during vectoring is not taken and blocks late arrival
    vec_active = 1; insn_bound = 1; tick("R7");
    quiet(); insn_bound = 1; e_pend = 0; e_halt = 1; tick("R3");
    quiet();

    // R10: hold, no queueing, release on ack
    tick("R10");
    evt_pulse = 8'h80; tick("R10");
    quiet(); halt_ack = 1; e_halt = 0; tick("R10");
    quiet(); insn_bound = 1; tick("R10");
    quiet();

    // R5: only mem-manage enabled, pulse coprocessor (event 2)
    wr("R5", 17'h00010, 17'h00010);
    evt_pulse = 8'h04; tick("R5");
    quiet(); insn_bound = 1; tick("R5");
    quiet();
    wr("R5", 17'h107F1, 17'h107F1);

    // R11: reset and hard fault together make one request
    evt_pulse = 8'h81; e_pend = 1; e_cause = 8'h81; tick("R11");
    quiet(); insn_bound = 1; e_pend = 0; e_halt = 1; tick("R11");
    quiet(); insn_bound = 1; tick("R11");
    quiet(); halt_ack = 1; e_halt = 0; tick("R11");
    quiet();

    // R6: fault during vectoring redirects the halt
    evt_pulse = 8'h20; e_pend = 1; e_cause = 8'h20; e_redir = 0; tick("R6");
    quiet(); vec_active = 1; vec_fault = 1; e_redir = 1; tick("R6");
    quiet(); vec_active = 1; tick("R6");
    quiet(); insn_bound = 1; e_pend = 0; e_halt = 1; tick("R6");
    quiet(); halt_ack = 1; e_halt = 0; tick("R6");
    quiet();

    // R9: reset catch held through core reset
    core_in_reset = 1; evt_pulse = 8'h01; e_pend = 1; e_cause = 8'h01; e_redir = 0; tick("R9");
    quiet(); insn_bound = 1; tick("R9");
    quiet(); core_in_reset = 0; tick("R9");
    insn_bound = 1; e_pend = 0; e_halt = 1; tick("R9");
    quiet(); halt_ack = 1; e_halt = 0; tick("R9");
    quiet();
    tick("R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule